// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware activity for later software inspection. It holds one cycle counter and two event counters, all `CNT_W` bits wide. Each event counter watches one line of an event pulse vector, chosen by an 8-bit code. A single 32-bit control word holds the settings, the sticky wrap flags and two self-clearing reset actions. The control word and the three counters are reached through a small register port. Writes take effect at the clock edge. Reads are combinational on the current address.

No counter has its own enable bit. Software parks an event counter by giving it a code that matches no event line. The cycle counter runs whenever the global enable is set. It can be slowed by a prescaler so that it advances once per `2**PRE_W` enabled cycles.

Each counter sets a sticky flag when it wraps. Software clears a flag by writing a one to that flag's position in the control word. One shared interrupt line is driven from the flags and their enables.

Top module: `perf_mon_unit`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq_o` is low.
- R2: Register addresses are: 0 for the control word, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. The control word reads back as follows:
  - bit 0: global enable
  - bit 3: divide mode
  - bits 6:4: interrupt enables, with bit 4 for counter 0, bit 5 for counter 1 and bit 6 for the cycle counter
  - bits 10:8: wrap flags, in the same order as the interrupt enables
  - bits 19:12: event code for counter 1
  - bits 27:20: event code for counter 0
  - all other bits read zero
- R3: While the global enable is low, no counter changes except through a register write.
- R4: With the global enable set, an event counter adds one at each clock edge where `events_i[code]` is high. A code of `NUM_EVT` or above, such as 0x20, never advances the counter.
- R5: With the global enable set and divide mode off, the cycle counter adds one at every clock edge.
- R6: With divide mode on, the cycle counter adds one once per 64 enabled edges. The first step comes on the 64th edge after the prescaler is cleared. The prescaler is cleared together with the cycle counter.
- R7: Writing a 1 to control bit 1 zeroes both event counters. Writing a 1 to control bit 2 zeroes the cycle counter. Both bits read back as zero and take effect only once.
- R8: A counter can be loaded by writing its address. In the same cycle, a load takes priority over an increment, and a load does not set the wrap flag.
- R9: A counter that steps from all ones to zero sets its wrap flag.
- R10: Writing a 1 to a wrap flag bit clears it. Writing a 0 leaves it unchanged. Writing back a value just read clears only the flags that were set and changes no other field.
- R11: If a wrap and a clear of the same flag happen in the same cycle, the flag stays set.
- R12: `irq_o` is high exactly when some wrap flag and its interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| events_i | input | NUM_EVT | Event pulses; bit k is event code k |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
The bench builds the block with its default parameters:
- `CNT_W` of 32
- `NUM_EVT` of 19
- `PRE_W` of 6

With these settings the divide-by-64 step is observed directly. Preloading a counter to all ones brings a 32-bit wrap within one cycle. The bench drives a load and an event pulse in the same cycle to test load priority. It drives a wrap together with a flag clear to test that a set wins over a clear. It also drives events with a parked code and with the global enable off. A behavioural model tracks all four registers and the interrupt on every clock.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;

    localparam int DATA_W     = 32;
    localparam int SEL_W      = 8;
    localparam int NUM_SRC    = 3;   // 0: event ctr 0, 1: event ctr 1, 2: cycle ctr

    localparam int B_EN       = 0;
    localparam int B_RST_EVT  = 1;
    localparam int B_RST_CYC  = 2;
    localparam int B_DIV      = 3;
    localparam int B_IEN      = 4;
    localparam int B_FLAG     = 8;
    localparam int B_SEL1     = 12;
    localparam int B_SEL0     = 20;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_CYCLE = 2'd1,
        REG_EVT0  = 2'd2,
        REG_EVT1  = 2'd3
    } pmu_reg_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel0;
        logic [SEL_W-1:0]   sel1;
        logic [NUM_SRC-1:0] ien;
        logic               div;
        logic               en;
    } pmu_cfg_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(pmu_cfg_t c, logic [NUM_SRC-1:0] f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_EN]              = c.en;
        v[B_DIV]             = c.div;
        v[B_IEN +: NUM_SRC]  = c.ien;
        v[B_FLAG +: NUM_SRC] = f;
        v[B_SEL1 +: SEL_W]   = c.sel1;
        v[B_SEL0 +: SEL_W]   = c.sel0;
        return v;
    endfunction

    function automatic pmu_cfg_t unpack_cfg(logic [DATA_W-1:0] v);
        pmu_cfg_t c;
        c.en   = v[B_EN];
        c.div  = v[B_DIV];
        c.ien  = v[B_IEN +: NUM_SRC];
        c.sel1 = v[B_SEL1 +: SEL_W];
        c.sel0 = v[B_SEL0 +: SEL_W];
        return c;
    endfunction

endpackage

// File: rtl/pmu_ctrl_reg.sv
`timescale 1ns/1ps
module pmu_ctrl_reg
    import pmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0]  ovf_set,
    output pmu_cfg_t            cfg,
    output logic [NUM_SRC-1:0]  flags,
    output logic                rst_evt,
    output logic                rst_cyc
);

    pmu_cfg_t           cfg_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] flag_clr;
    logic               unused_bits;

    assign unused_bits = ^{wdata[DATA_W-1:B_SEL0+SEL_W], wdata[B_FLAG+NUM_SRC], wdata[B_IEN+NUM_SRC]};

    assign rst_evt  = wr & wdata[B_RST_EVT];
    assign rst_cyc  = wr & wdata[B_RST_CYC];
    assign flag_clr = wr ? wdata[B_FLAG +: NUM_SRC] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr) begin
                cfg_q <= unpack_cfg(wdata);
            end
            // a hardware set in the same cycle overrides a software clear
            flag_q <= (flag_q & ~flag_clr) | ovf_set;
        end
    end

    assign cfg   = cfg_q;
    assign flags = flag_q;

endmodule

// File: rtl/pmu_event_counter.sv
`timescale 1ns/1ps
module pmu_event_counter #(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 19,
    parameter int SEL_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               count_en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] events,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               clear,
    output logic [CNT_W-1:0]   count,
    output logic               wrap
);

    logic             picked;
    logic             hit;
    logic [CNT_W-1:0] cnt_q;

    // codes past the last event line select nothing, which parks the counter
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel == SEL_W'(i)) begin
                picked = events[i];
            end
        end
    end

    assign hit  = count_en & picked;
    assign wrap = hit & (&cnt_q) & ~load & ~clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/pmu_cycle_counter.sv
`timescale 1ns/1ps
module pmu_cycle_counter #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             div_mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step = count_en & (~div_mode | (&pre_q));
    assign wrap = step & (&cnt_q) & ~load & ~clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
        end else if (count_en && div_mode) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/1ps
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 19,
    parameter int PRE_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] events_i,
    output logic               irq_o
);

    localparam int NUM_EVT_CTR = 2;

    pmu_reg_e           addr;
    pmu_cfg_t           cfg;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] ovf_set;
    logic               rst_evt;
    logic               rst_cyc;
    logic               wr_ctrl;
    logic               wr_cyc;
    logic               cfg_en;
    logic [CNT_W-1:0]   cyc_cnt;
    logic [CNT_W-1:0]   evt_cnt [NUM_EVT_CTR];
    logic [SEL_W-1:0]   evt_sel [NUM_EVT_CTR];
    logic [CNT_W-1:0]   evt_cnt0;
    logic [CNT_W-1:0]   evt_cnt1;
    logic [CNT_W-1:0]   load_val;

    assign addr     = pmu_reg_e'(reg_addr);
    assign wr_ctrl  = reg_wr_en && (addr == REG_CTRL);
    assign wr_cyc   = reg_wr_en && (addr == REG_CYCLE);
    assign load_val = reg_wdata[CNT_W-1:0];
    assign cfg_en   = cfg.en;
    assign evt_sel[0] = cfg.sel0;
    assign evt_sel[1] = cfg.sel1;

    pmu_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_ctrl),
        .wdata   (reg_wdata),
        .ovf_set (ovf_set),
        .cfg     (cfg),
        .flags   (flags),
        .rst_evt (rst_evt),
        .rst_cyc (rst_cyc)
    );

    for (genvar g = 0; g < NUM_EVT_CTR; g++) begin : g_evt
        logic wr_this;
        assign wr_this = reg_wr_en && (addr == pmu_reg_e'(REG_EVT0 + g));

        pmu_event_counter #(
            .CNT_W   (CNT_W),
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W)
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .count_en (cfg.en),
            .sel      (evt_sel[g]),
            .events   (events_i),
            .load     (wr_this),
            .load_val (load_val),
            .clear    (rst_evt),
            .count    (evt_cnt[g]),
            .wrap     (ovf_set[g])
        );
    end

    pmu_cycle_counter #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W)
    ) u_cyc (
        .clk      (clk),
        .rst      (rst),
        .count_en (cfg.en),
        .div_mode (cfg.div),
        .load     (wr_cyc),
        .load_val (load_val),
        .clear    (rst_cyc),
        .count    (cyc_cnt),
        .wrap     (ovf_set[2])
    );

    assign evt_cnt0 = evt_cnt[0];
    assign evt_cnt1 = evt_cnt[1];

    always_comb begin
        case (addr)
            REG_CTRL:  reg_rdata = pack_ctrl(cfg, flags);
            REG_CYCLE: reg_rdata = DATA_W'(cyc_cnt);
            REG_EVT0:  reg_rdata = DATA_W'(evt_cnt0);
            default:   reg_rdata = DATA_W'(evt_cnt1);
        endcase
    end

    assign irq_o = |(flags & cfg.ien);

endmodule

// File: rtl/pmu_checker.sv
`timescale 1ns/1ps
module pmu_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             cfg_en,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] cyc,
    input logic [2:0]       flags
);

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !reg_wr_en) |=> ($stable(cnt0) && $stable(cnt1) && $stable(cyc)));

    assert_evt_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd0 && reg_wdata[1]) |=> (cnt0 == '0 && cnt1 == '0));

    assert_cyc_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd0 && reg_wdata[2]) |=> (cyc == '0));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd2) |=> (cnt0 == $past(reg_wdata[CNT_W-1:0])));

    assert_wrap_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr_en && cnt0 == '1) |=> (cnt0 != '0 || flags[0]));

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> (cnt1 == '0));

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (flags[2] && !(reg_wr_en && reg_addr == 2'd0)) |=> flags[2]);

endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W)) u_pmu_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg_en    (cfg_en),
    .cnt0      (evt_cnt0),
    .cnt1      (evt_cnt1),
    .cyc       (cyc_cnt),
    .flags     (flags)
);

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
module test_perf_mon_unit;

    localparam int NE = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [NE-1:0] ev = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [31:0] m_cyc, m_c0, m_c1;
    logic        m_en, m_div;
    logic [2:0]  m_ien, m_flag;
    logic [7:0]  m_s0, m_s1;
    int          m_pre;

    always #2.5 clk = ~clk;

    perf_mon_unit i_perf_mon_unit (
        .clk       (clk),
        .rst       (rst),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .events_i  (ev),
        .irq_o     (irq)
    );

    function automatic logic [31:0] ctl(logic en, logic dv, logic [2:0] ie, logic [7:0] s0, logic [7:0] s1);
        return {4'h0, s0, s1, 1'b0, 3'b000, 1'b0, ie, dv, 2'b00, en};
    endfunction

    function automatic logic [31:0] m_read(logic [1:0] a);
        case (a)
            2'd0:    return {4'h0, m_s0, m_s1, 1'b0, m_flag, 1'b0, m_ien, m_div, 2'b00, m_en};
            2'd1:    return m_cyc;
            2'd2:    return m_c0;
            default: return m_c1;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic h0, h1, hc, wc, s0, s1, sc;
        int i0, i1;
        if (rst) begin
            m_cyc = '0; m_c0 = '0; m_c1 = '0; m_en = 0; m_div = 0;
            m_ien = '0; m_flag = '0; m_s0 = '0; m_s1 = '0; m_pre = 0;
        end else begin
            wc = reg_wr_en && reg_addr == 2'd0;
            i0 = m_s0; i1 = m_s1;
            h0 = m_en && i0 < NE && ev[i0 % NE];
            h1 = m_en && i1 < NE && ev[i1 % NE];
            hc = m_en && (!m_div || m_pre == 63);
            s0 = h0 && m_c0 == 32'hFFFF_FFFF && !(reg_wr_en && reg_addr == 2'd2) && !(wc && reg_wdata[1]);
            s1 = h1 && m_c1 == 32'hFFFF_FFFF && !(reg_wr_en && reg_addr == 2'd3) && !(wc && reg_wdata[1]);
            sc = hc && m_cyc == 32'hFFFF_FFFF && !(reg_wr_en && reg_addr == 2'd1) && !(wc && reg_wdata[2]);
            if (reg_wr_en && reg_addr == 2'd2) m_c0 = reg_wdata;
            else if (wc && reg_wdata[1])       m_c0 = '0;
            else if (h0)                       m_c0 = m_c0 + 1;
            if (reg_wr_en && reg_addr == 2'd3) m_c1 = reg_wdata;
            else if (wc && reg_wdata[1])       m_c1 = '0;
            else if (h1)                       m_c1 = m_c1 + 1;
            if (reg_wr_en && reg_addr == 2'd1) m_cyc = reg_wdata;
            else if (wc && reg_wdata[2])       m_cyc = '0;
            else if (hc)                       m_cyc = m_cyc + 1;
            if (wc && reg_wdata[2])            m_pre = 0;
            else if (m_en && m_div)            m_pre = (m_pre + 1) % 64;
            m_flag = (m_flag & ~(wc ? reg_wdata[10:8] : 3'b000)) | {sc, s1, s0};
            if (wc) begin
                m_en = reg_wdata[0]; m_div = reg_wdata[3]; m_ien = reg_wdata[6:4];
                m_s1 = reg_wdata[19:12]; m_s0 = reg_wdata[27:20];
            end
        end
    end

    // model comparison on every clock (R2 readback, R12 interrupt)
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            chk("R2 model", reg_rdata, m_read(reg_addr));
            chk("R12 model", {31'b0, irq}, {31'b0, |(m_flag & m_ien)});
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse(logic [NE-1:0] m);
        ev = m;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic expect_reg(logic [1:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #0.1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic read_reg(logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v1, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_reg(0, 32'h0, "R1 ctrl");
        expect_reg(1, 32'h0, "R1 cycle");
        expect_reg(2, 32'h0, "R1 ctr0");
        expect_reg(3, 32'h0, "R1 ctr1");
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 disabled: events ignored
        wr(0, ctl(0, 0, 3'b000, 8'd3, 8'd5));
        repeat (3) pulse(NE'(1 << 3) | NE'(1 << 5));
        expect_reg(2, 32'h0, "R3 ctr0");
        expect_reg(3, 32'h0, "R3 ctr1");
        expect_reg(1, 32'h0, "R3 cycle");

        // R4 event selection
        wr(0, ctl(1, 0, 3'b000, 8'd3, 8'd5));
        repeat (4) begin pulse(NE'(1 << 3)); @(negedge clk); end
        repeat (2) pulse(NE'(1 << 5));
        repeat (2) pulse(NE'(1 << 7));
        expect_reg(2, 32'd4, "R4 ctr0");
        expect_reg(3, 32'd2, "R4 ctr1");

        // R5 cycle counter every edge
        read_reg(1, v1);
        repeat (10) @(negedge clk);
        read_reg(1, v2);
        chk("R5 cycle delta", v2 - v1, 32'd10);

        // R4 parked code 0x20
        wr(0, ctl(1, 0, 3'b000, 8'h20, 8'd5));
        repeat (3) pulse('1);
        expect_reg(2, 32'd4, "R4 parked ctr0");
        expect_reg(3, 32'd5, "R4 live ctr1");

        // R2 field positions and unused bits
        wr(0, ctl(1, 0, 3'b000, 8'hA5, 8'h3C) | 32'hF000_0880);
        expect_reg(0, 32'h0A53_C001, "R2 ctrl readback");

        // R7 one-shot resets
        wr(0, ctl(1, 0, 3'b000, 8'd3, 8'd5) | 32'h2);
        expect_reg(2, 32'h0, "R7 ctr0 reset");
        expect_reg(3, 32'h0, "R7 ctr1 reset");
        expect_reg(0, ctl(1, 0, 3'b000, 8'd3, 8'd5), "R7 bit1 reads 0");
        wr(0, ctl(1, 0, 3'b000, 8'd3, 8'd5) | 32'h4);
        expect_reg(1, 32'h0, "R7 cycle reset");

        // R8 preload and load priority
        wr(2, 32'hFFFF_FFFE);
        pulse(NE'(1 << 3));
        expect_reg(2, 32'hFFFF_FFFF, "R8 preload step");
        reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h100; ev = NE'(1 << 3);
        @(negedge clk);
        reg_wr_en = 1'b0; ev = '0;
        expect_reg(2, 32'h100, "R8 load wins");
        expect_reg(0, ctl(1, 0, 3'b000, 8'd3, 8'd5), "R8 no flag on load");

        // R9 wrap sets flag; R12 masked
        wr(2, 32'hFFFF_FFFF);
        pulse(NE'(1 << 3));
        expect_reg(2, 32'h0, "R9 ctr0 wrapped");
        expect_reg(0, ctl(1, 0, 3'b000, 8'd3, 8'd5) | 32'h100, "R9 flag0 set");
        chk("R12 masked irq", {31'b0, irq}, 32'h0);

        // R10 writing 0 keeps flag; R12 enable raises irq
        wr(0, ctl(1, 0, 3'b001, 8'd3, 8'd5));
        expect_reg(0, ctl(1, 0, 3'b001, 8'd3, 8'd5) | 32'h100, "R10 zero keeps flag");
        chk("R12 irq raised", {31'b0, irq}, 32'h1);

        // R10 write-back clears flag only
        read_reg(0, v1);
        wr(0, v1);
        expect_reg(0, ctl(1, 0, 3'b001, 8'd3, 8'd5), "R10 write-back");
        chk("R12 irq cleared", {31'b0, irq}, 32'h0);

        // R11 set beats clear
        wr(3, 32'hFFFF_FFFF);
        pulse(NE'(1 << 5));
        expect_reg(0, ctl(1, 0, 3'b001, 8'd3, 8'd5) | 32'h200, "R9 flag1 set");
        wr(3, 32'hFFFF_FFFF);
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = ctl(1, 0, 3'b001, 8'd3, 8'd5) | 32'h200;
        ev = NE'(1 << 5);
        @(negedge clk);
        reg_wr_en = 1'b0; ev = '0;
        expect_reg(0, ctl(1, 0, 3'b001, 8'd3, 8'd5) | 32'h200, "R11 set wins");
        expect_reg(3, 32'h0, "R11 ctr1 wrapped");
        wr(0, ctl(1, 0, 3'b000, 8'd3, 8'd5) | 32'h200);

        // R6 divided cycle count
        wr(0, ctl(1, 1, 3'b000, 8'd3, 8'd5) | 32'h4);
        repeat (63) @(negedge clk);
        expect_reg(1, 32'd0, "R6 before 64th edge");
        @(negedge clk);
        expect_reg(1, 32'd1, "R6 at 64th edge");
        repeat (64) @(negedge clk);
        expect_reg(1, 32'd2, "R6 second step");

        // R9 cycle wrap with R12 interrupt
        wr(0, ctl(1, 0, 3'b100, 8'd3, 8'd5));
        wr(1, 32'hFFFF_FFFF);
        @(negedge clk);
        expect_reg(1, 32'h0, "R9 cycle wrapped");
        expect_reg(0, ctl(1, 0, 3'b100, 8'd3, 8'd5) | 32'h400, "R9 flag2 set");
        chk("R12 cycle irq", {31'b0, irq}, 32'h1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule